// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Sequencer

This block loads a bitstream into a downstream FPGA through its byte-wide slave parallel configuration port. A single `start_i` pulse launches the sequence. The block first pulses the target's program line low to clear its configuration memory. It then waits for the target's INIT line to fall and to rise again. Next it enables the port by asserting chip-select and write. After that it takes bytes from a valid/ready stream and clocks each one into the target on a rising configuration-clock edge. When the stream's last byte has gone out, it releases the port and waits for the target to signal completion.

Every waiting phase has its own limit in milliseconds. A millisecond tick is derived from the system clock frequency parameter. When the target reports a CRC error, stays busy, or never finishes, the sequencer abandons the load. It then releases the port lines, stops accepting bytes and raises `fail_o` with a code naming the phase that failed. `done_o` and `fail_o`, together with the code, stay valid until the next start.

The control is one state machine with these states: `ST_IDLE`, `ST_PROG`, `ST_INIT_HI`, `ST_ARM`, `ST_FETCH`, `ST_SETUP`, `ST_CLK_LO`, `ST_CLK_HI`, `ST_BUSY`, `ST_FIN_CS`, `ST_FIN_WR` and `ST_CHECK`.

Transitions:
- `ST_IDLE`→`ST_PROG` on start.
- `ST_PROG`→`ST_INIT_HI` once the minimum pulse has elapsed and INIT is low. `ST_PROG`→`ST_IDLE` on timeout.
- `ST_INIT_HI`→`ST_ARM` when INIT is high. `ST_INIT_HI`→`ST_IDLE` on timeout.
- `ST_ARM`→`ST_FETCH`.
- From `ST_FETCH`: to `ST_FIN_CS` if DONE is high; to `ST_IDLE` if INIT is low; to `ST_SETUP` when a byte is accepted.
- `ST_SETUP`→`ST_CLK_LO`→`ST_CLK_HI`, each step after one half period.
- From `ST_CLK_HI`: to `ST_BUSY` when BUSY checking is on; otherwise to `ST_FIN_CS` after the last byte, or to `ST_FETCH`.
- From `ST_BUSY`: to `ST_FETCH` or `ST_FIN_CS` once BUSY is clear; to `ST_IDLE` on timeout.
- `ST_FIN_CS`→`ST_FIN_WR`→`ST_CHECK`.
- From `ST_CHECK`: to `ST_IDLE` with success, or to `ST_IDLE` with failure on timeout.

Top module: `cfg_loader`

## Requirements
- R1: After reset, and whenever the block is idle, `prog_n_o`, `cs_n_o` and `wr_n_o` are 1 and `byte_ready_o` is 0. After reset, `done_o`, `fail_o` and `err_code_o` are 0.
- R2: After a start, `prog_n_o` stays 0 for at least `PROG_LOW_CYC` cycles and until `init_n_i` is 0. If `init_n_i` is not 0 within `INIT_TMO_MS` ms of the start, the load fails with code 1.
- R3: After `prog_n_o` is released, `cclk_o` is 1 and the block waits for `init_n_i` to be 1. If that does not happen within `INIT_TMO_MS` ms, the load fails with code 2.
- R4: `cs_n_o` and `wr_n_o` go to 0 only after `init_n_i` has been seen at 1. `byte_ready_o` is 1 only while both are 0.
- R5: An accepted byte is placed on `cdata_o` and held while `cclk_o` goes 0 and then back to 1. The byte is captured by the target on that rising edge. While chip-select is active, each level of `cclk_o` lasts at least `CCLK_HALF` cycles.
- R6: If `done_i` is 1 when the next byte is due, no further byte is accepted and the block goes to the completion check without an error.
- R7: If `init_n_i` is 0 when the next byte is due, the load fails with code 3.
- R8: With `CHECK_BUSY` set, no rising `cclk_o` edge occurs while `busy_i` is 1. If `busy_i` stays 1 for `BUSY_TMO_MS` ms after a byte, the load fails with code 4.
- R9: After the last byte, `cs_n_o` returns to 1 one cycle before `wr_n_o`. The load then succeeds (`done_o`=1, code 0) once `done_i` is 1 and `init_n_i` is 1. If that does not happen within `DONE_TMO_MS` ms, the load fails with code 5.
- R10: On any failure, `prog_n_o`, `cs_n_o` and `wr_n_o` are 1 and `byte_ready_o` is 0. `fail_o` and `err_code_o` hold until the next start, which clears them along with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a load; honoured only when idle |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_data_i | input | DW | Stream byte |
| byte_last_i | input | 1 | Marks the final byte of the bitstream |
| byte_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| prog_n_o | output | 1 | Program line to target, active low |
| cs_n_o | output | 1 | Chip-select to target, active low |
| wr_n_o | output | 1 | Write enable to target, active low |
| cclk_o | output | 1 | Configuration clock to target |
| cdata_o | output | DW | Configuration data bus |
| init_n_i | input | 1 | Target INIT line, active low, synchronised |
| busy_i | input | 1 | Target busy flag, synchronised |
| done_i | input | 1 | Target done flag, synchronised |
| done_o | output | 1 | Last load succeeded |
| fail_o | output | 1 | Last load failed |
| err_code_o | output | 3 | Failing phase: 0 none, 1 INIT-low timeout, 2 INIT-high timeout, 3 CRC, 4 busy timeout, 5 done timeout |

## Verification
The bench builds the block with `CLK_HZ` = 8000, so one millisecond is 8 cycles. The timeouts are set to 3, 2 and 2 ms, the program pulse to 4 cycles, a half period of 2 cycles, and BUSY checking on. With these values every timeout expires within a few dozen cycles. That lets the bench measure each limit exactly against its millisecond arithmetic, and sweep every stream length from 1 to 8 bytes with and without a busy target. A behavioural target model drives INIT, BUSY and DONE, and captures bytes on rising clock edges. It can inject a stuck INIT, a CRC drop, a stuck BUSY, an early DONE or a missing DONE at any chosen byte.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_INIT_HI,
        ST_ARM,
        ST_FETCH,
        ST_SETUP,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_BUSY,
        ST_FIN_CS,
        ST_FIN_WR,
        ST_CHECK
    } ld_state_t;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_INIT_LO   = 3'd1,
        ERR_INIT_HI   = 3'd2,
        ERR_CRC       = 3'd3,
        ERR_BUSY      = 3'd4,
        ERR_DONE      = 3'd5
    } ld_err_t;

endpackage

// File: rtl/cfg_ms_timer.sv
// Millisecond timeout: a prescaler produces one tick per TICK_CYC cycles,
// a saturating tick counter compares against the selected limit.
module cfg_ms_timer #(
    parameter int TICK_CYC = 1000,
    parameter int MSW      = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic [MSW-1:0] limit_ms,
    output logic           expired
);
    localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

    logic [PW-1:0]  pre_q;
    logic [MSW-1:0] ms_q;
    logic           wrap;

    assign wrap = (pre_q == PW'(TICK_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else begin
            pre_q <= wrap ? '0 : pre_q + 1'b1;
            if (wrap && (ms_q != '1)) begin
                ms_q <= ms_q + 1'b1;
            end
        end
    end

    assign expired = (ms_q >= limit_ms);

    // R2/R3/R8/R9 timeouts rely on the prescaler never leaving its range
    a_r2_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PW'(TICK_CYC - 1));

endmodule

// File: rtl/cfg_span_cnt.sv
// Dwell counter: reached goes high in the limit-th cycle after clear.
module cfg_span_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         reached
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int PROG_LOW_CYC = (CLK_HZ / 10_000_000) * 3 + 3,
    parameter int CCLK_HALF    = 1,
    parameter int INIT_TMO_MS  = 500,
    parameter int BUSY_TMO_MS  = 5,
    parameter int DONE_TMO_MS  = 200,
    parameter bit CHECK_BUSY   = 1'b1,
    parameter int DW           = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          byte_valid_i,
    input  logic [DW-1:0] byte_data_i,
    input  logic          byte_last_i,
    output logic          byte_ready_o,
    output logic          prog_n_o,
    output logic          cs_n_o,
    output logic          wr_n_o,
    output logic          cclk_o,
    output logic [DW-1:0] cdata_o,
    input  logic          init_n_i,
    input  logic          busy_i,
    input  logic          done_i,
    output logic          done_o,
    output logic          fail_o,
    output logic [2:0]    err_code_o
);
    localparam int TICK_CYC = (CLK_HZ >= 2000) ? CLK_HZ / 1000 : 1;
    localparam int TMO_A    = (INIT_TMO_MS > BUSY_TMO_MS) ? INIT_TMO_MS : BUSY_TMO_MS;
    localparam int TMO_MAX  = (TMO_A > DONE_TMO_MS) ? TMO_A : DONE_TMO_MS;
    localparam int MSW      = $clog2(TMO_MAX + 1);
    localparam int SPAN_MAX = (PROG_LOW_CYC > CCLK_HALF) ? PROG_LOW_CYC : CCLK_HALF;
    localparam int SPW      = $clog2(SPAN_MAX + 1);

    ld_state_t      state_q, state_d;
    logic [DW-1:0]  data_q;
    logic           last_q;
    logic           done_q, fail_q;
    ld_err_t        err_q;

    logic           phase_clear;
    logic           tmo_hit, span_hit;
    logic [MSW-1:0] tmo_limit;
    logic [SPW-1:0] span_limit;
    logic           accept;
    logic           abort_now;
    ld_err_t        abort_code;

    assign phase_clear = (state_d != state_q);

    always_comb begin
        unique case (state_q)
            ST_PROG, ST_INIT_HI: tmo_limit = MSW'(INIT_TMO_MS);
            ST_BUSY:             tmo_limit = MSW'(BUSY_TMO_MS);
            default:             tmo_limit = MSW'(DONE_TMO_MS);
        endcase
        span_limit = (state_q == ST_PROG) ? SPW'(PROG_LOW_CYC) : SPW'(CCLK_HALF);
    end

    cfg_ms_timer #(.TICK_CYC(TICK_CYC), .MSW(MSW)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (phase_clear),
        .limit_ms (tmo_limit),
        .expired  (tmo_hit)
    );

    cfg_span_cnt #(.W(SPW)) u_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (phase_clear),
        .limit   (span_limit),
        .reached (span_hit)
    );

    assign accept = byte_valid_i && byte_ready_o;

    // next-state logic
    always_comb begin
        state_d    = state_q;
        abort_now  = 1'b0;
        abort_code = ERR_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (span_hit && !init_n_i) begin
                    state_d = ST_INIT_HI;
                end else if (tmo_hit) begin
                    abort_now  = 1'b1;
                    abort_code = ERR_INIT_LO;
                end
            end
            ST_INIT_HI: begin
                if (init_n_i) begin
                    state_d = ST_ARM;
                end else if (tmo_hit) begin
                    abort_now  = 1'b1;
                    abort_code = ERR_INIT_HI;
                end
            end
            ST_ARM:  state_d = ST_FETCH;
            ST_FETCH: begin
                if (done_i) begin
                    state_d = ST_FIN_CS;
                end else if (!init_n_i) begin
                    abort_now  = 1'b1;
                    abort_code = ERR_CRC;
                end else if (accept) begin
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP:  if (span_hit) state_d = ST_CLK_LO;
            ST_CLK_LO: if (span_hit) state_d = ST_CLK_HI;
            ST_CLK_HI: begin
                if (span_hit) begin
                    if (CHECK_BUSY)  state_d = ST_BUSY;
                    else if (last_q) state_d = ST_FIN_CS;
                    else             state_d = ST_FETCH;
                end
            end
            ST_BUSY: begin
                if (!busy_i) begin
                    state_d = last_q ? ST_FIN_CS : ST_FETCH;
                end else if (tmo_hit) begin
                    abort_now  = 1'b1;
                    abort_code = ERR_BUSY;
                end
            end
            ST_FIN_CS: state_d = ST_FIN_WR;
            ST_FIN_WR: state_d = ST_CHECK;
            ST_CHECK: begin
                if (done_i && init_n_i) begin
                    state_d = ST_IDLE;
                end else if (tmo_hit) begin
                    abort_now  = 1'b1;
                    abort_code = ERR_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort_now) state_d = ST_IDLE;
    end

    // state and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                done_q <= 1'b0;
                fail_q <= 1'b0;
                err_q  <= ERR_NONE;
            end
            if (abort_now) begin
                fail_q <= 1'b1;
                err_q  <= abort_code;
            end
            if (state_q == ST_CHECK && done_i && init_n_i) begin
                done_q <= 1'b1;
            end
            if (state_q == ST_FETCH && state_d == ST_SETUP) begin
                data_q <= byte_data_i;
                last_q <= byte_last_i;
            end
        end
    end

    // Moore outputs
    always_comb begin
        prog_n_o     = 1'b1;
        cs_n_o       = 1'b1;
        wr_n_o       = 1'b1;
        cclk_o       = 1'b1;
        byte_ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    cclk_o = 1'b0;
            ST_PROG: begin
                prog_n_o = 1'b0;
                cclk_o   = 1'b0;
            end
            ST_INIT_HI: ;
            ST_ARM, ST_SETUP, ST_CLK_HI, ST_BUSY: begin
                cs_n_o = 1'b0;
                wr_n_o = 1'b0;
            end
            ST_FETCH: begin
                cs_n_o       = 1'b0;
                wr_n_o       = 1'b0;
                byte_ready_o = !done_i && init_n_i;
            end
            ST_CLK_LO: begin
                cs_n_o = 1'b0;
                wr_n_o = 1'b0;
                cclk_o = 1'b0;
            end
            ST_FIN_CS:  wr_n_o = 1'b0;
            ST_FIN_WR, ST_CHECK: ;
            default: ;
        endcase
    end

    assign cdata_o    = data_q;
    assign done_o     = done_q;
    assign fail_o     = fail_q;
    assign err_code_o = err_q;

    // program pulse length observed at the pin
    logic [31:0] prog_low_run;
    always_ff @(posedge clk) begin
        if (!rst_n || prog_n_o) prog_low_run <= '0;
        else if (prog_low_run != '1) prog_low_run <= prog_low_run + 1'b1;
    end

    a_r2_prog_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prog_n_o) && !fail_o) |-> (prog_low_run >= 32'(PROG_LOW_CYC)));

    a_r4_arm_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(init_n_i));

    a_r4_ready_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (!cs_n_o && !wr_n_o && prog_n_o));

    a_r5_data_stable_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cclk_o) && !cs_n_o) |-> $stable(cdata_o));

    a_r9_cs_before_wr: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_n_o) && !fail_o) |-> $past(cs_n_o));

    a_r10_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> (prog_n_o && cs_n_o && wr_n_o && !byte_ready_o));

    a_r10_result_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

endmodule

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;

    localparam int HZ    = 8000;
    localparam int TICK  = HZ / 1000;
    localparam int PLOW  = 4;
    localparam int HALF  = 2;
    localparam int TINIT = 3;
    localparam int TBUSY = 2;
    localparam int TDONE = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i, byte_valid_i, byte_last_i;
    logic [7:0] byte_data_i;
    logic       byte_ready_o, prog_n_o, cs_n_o, wr_n_o, cclk_o;
    logic [7:0] cdata_o;
    logic       init_n_i, busy_i, done_i;
    logic       done_o, fail_o;
    logic [2:0] err_code_o;

    always #2 clk = ~clk;

    cfg_loader #(
        .CLK_HZ(HZ), .PROG_LOW_CYC(PLOW), .CCLK_HALF(HALF),
        .INIT_TMO_MS(TINIT), .BUSY_TMO_MS(TBUSY), .DONE_TMO_MS(TDONE),
        .CHECK_BUSY(1'b1), .DW(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .byte_last_i(byte_last_i), .byte_ready_o(byte_ready_o),
        .prog_n_o(prog_n_o), .cs_n_o(cs_n_o), .wr_n_o(wr_n_o),
        .cclk_o(cclk_o), .cdata_o(cdata_o),
        .init_n_i(init_n_i), .busy_i(busy_i), .done_i(done_i),
        .done_o(done_o), .fail_o(fail_o), .err_code_o(err_code_o)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // target model controls
    int m_lo_delay, m_crc_at, m_stuck_at, m_done_at, m_busy_len;
    bit m_hi_never;
    // target model state
    int pl, rel, ncap, busy_left, prog_max, pace_cnt, pace_bad, busy_bad, post_cnt;
    bit crc_hit, prev_cclk, order_seen;
    logic [7:0] cap [0:15];

    always @(negedge clk) begin
        if (rst_n) begin
            if (!prog_n_o) begin
                pl++;
                if (pl > prog_max) prog_max = pl;
                rel = 0; ncap = 0; done_i = 1'b0; busy_left = 0; busy_i = 1'b0; crc_hit = 0;
                if (m_lo_delay >= 0 && pl > m_lo_delay) init_n_i = 1'b0;
            end else begin
                pl = 0;
                if (!init_n_i && !crc_hit && !m_hi_never) begin
                    rel++;
                    if (rel > 2) init_n_i = 1'b1;
                end
                if (cclk_o && !prev_cclk && !cs_n_o && !wr_n_o) begin
                    if (busy_i) busy_bad++;
                    if (ncap < 16) cap[ncap] = cdata_o;
                    ncap++;
                    busy_left = (ncap == m_stuck_at) ? 1000000 : m_busy_len;
                    if (ncap == m_crc_at) begin init_n_i = 1'b0; crc_hit = 1; end
                    if (ncap == m_done_at) done_i = 1'b1;
                end else if (busy_left > 0) begin
                    busy_left--;
                end
                busy_i = (busy_left > 0);
            end
            if (!cs_n_o) begin
                if (cclk_o != prev_cclk) begin
                    if (pace_cnt < HALF) pace_bad++;
                    pace_cnt = 1;
                end else pace_cnt++;
            end else pace_cnt = 99;
            if (cs_n_o && !wr_n_o) order_seen = 1;
            if (cs_n_o && wr_n_o && prog_n_o && ncap > 0 && !done_o && !fail_o) post_cnt++;
            prev_cclk = cclk_o;
        end
    end

    function automatic logic [7:0] pat(input int i, input int len);
        return 8'((i * 29 + len * 7 + 3) & 255);
    endfunction

    // runs one load; returns with inputs idle, sampled after the end
    task automatic run_load(input int len, input int lo_delay, input bit hi_never,
                            input int crc_at, input int stuck_at, input int done_at,
                            input int busy_len);
        int idx;
        int cyc;
        bit acc;
        m_lo_delay = lo_delay; m_hi_never = hi_never; m_crc_at = crc_at;
        m_stuck_at = stuck_at; m_done_at = done_at; m_busy_len = busy_len;
        prog_max = 0; pace_bad = 0; busy_bad = 0; order_seen = 0; post_cnt = 0;
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        idx = 0;
        byte_valid_i = (len > 0);
        byte_data_i  = pat(0, len);
        byte_last_i  = (len == 1);
        @(negedge clk); #1;
        // R10: a start clears the previous result
        chk(!fail_o && !done_o, "R10 start clears result", int'(fail_o) + int'(done_o), 0);
        cyc = 0;
        while (!(done_o || fail_o) && cyc < 3000) begin
            @(negedge clk); #1;
            acc = byte_valid_i && byte_ready_o;
            @(posedge clk); #1;
            cyc++;
            if (acc) begin
                idx++;
                if (idx < len) begin
                    byte_data_i = pat(idx, len);
                    byte_last_i = (idx == len - 1);
                end else byte_valid_i = 1'b0;
            end
        end
        byte_valid_i = 1'b0;
        @(negedge clk); #1;
    endtask

    task automatic check_release(input string req);
        chk(prog_n_o && cs_n_o && wr_n_o && !byte_ready_o, req,
            {prog_n_o, cs_n_o, wr_n_o, byte_ready_o}, 4'b1110);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; byte_valid_i = 1'b0; byte_last_i = 1'b0;
        byte_data_i = '0; init_n_i = 1'b1; busy_i = 1'b0; done_i = 1'b0;
        m_lo_delay = 2; m_hi_never = 0; m_crc_at = -1; m_stuck_at = -1;
        m_done_at = -1; m_busy_len = 0;
        pl = 0; rel = 0; ncap = 0; busy_left = 0; crc_hit = 0; prev_cclk = 0; pace_cnt = 99;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        check_release("R1 idle lines");
        chk(!done_o && !fail_o && err_code_o == 3'd0, "R1 result after reset",
            {done_o, fail_o, err_code_o}, 0);
        chk(cclk_o == 1'b0, "R1 idle clock", cclk_o, 0);

        // R5/R8/R9 normal loads, every length, with and without busy target
        for (int b = 0; b < 2; b++) begin
            for (int len = 1; len <= 8; len++) begin
                int bad;
                run_load(len, 2, 0, -1, -1, len, b * 3);
                chk(done_o && !fail_o && err_code_o == 3'd0, "R9 success",
                    {done_o, fail_o, err_code_o}, 5'b10000);
                chk(ncap == len, "R5 byte count", ncap, len);
                bad = 0;
                for (int i = 0; i < len && i < 16; i++) if (cap[i] !== pat(i, len)) bad++;
                chk(bad == 0, "R5 byte values", bad, 0);
                chk(pace_bad == 0, "R5 clock level width", pace_bad, 0);
                chk(busy_bad == 0, "R8 no edge while busy", busy_bad, 0);
                chk(order_seen, "R9 cs before wr", order_seen, 1);
                chk(prog_max >= PLOW, "R2 program pulse width", prog_max, PLOW);
                check_release("R1 idle after success");
            end
        end

        // R2 INIT never falls
        run_load(3, -1, 0, -1, -1, 3, 0);
        chk(fail_o && err_code_o == 3'd1, "R2 init-low timeout code", err_code_o, 1);
        chk(prog_max >= TINIT * TICK && prog_max <= TINIT * TICK + 2,
            "R2 timeout length", prog_max, TINIT * TICK + 1);
        check_release("R10 release after R2 abort");

        // R3 INIT never rises
        run_load(3, 2, 1, -1, -1, 3, 0);
        chk(fail_o && err_code_o == 3'd2, "R3 init-high timeout code", err_code_o, 2);
        chk(ncap == 0, "R3 no bytes sent", ncap, 0);

        // R7 CRC error after second byte
        run_load(5, 2, 0, 2, -1, -1, 0);
        chk(fail_o && err_code_o == 3'd3, "R7 crc code", err_code_o, 3);
        chk(ncap == 2, "R7 stops after error", ncap, 2);
        check_release("R10 release after R7 abort");
        repeat (5) @(negedge clk);
        #1 chk(fail_o && err_code_o == 3'd3, "R10 result held", err_code_o, 3);

        // R8 busy stuck after third byte
        run_load(5, 2, 0, -1, 3, -1, 0);
        chk(fail_o && err_code_o == 3'd4, "R8 busy timeout code", err_code_o, 4);
        chk(ncap == 3, "R8 no byte after stuck busy", ncap, 3);
        check_release("R10 release after R8 abort");

        // R9 done never rises
        run_load(4, 2, 0, -1, -1, -1, 0);
        chk(fail_o && err_code_o == 3'd5, "R9 done timeout code", err_code_o, 5);
        chk(post_cnt >= TDONE * TICK && post_cnt <= TDONE * TICK + 3,
            "R9 done timeout length", post_cnt, TDONE * TICK + 2);
        chk(ncap == 4, "R9 all bytes sent", ncap, 4);

        // R6 early done after two of six bytes
        run_load(6, 2, 0, -1, -1, 2, 0);
        chk(done_o && !fail_o && err_code_o == 3'd0, "R6 early done success",
            {done_o, fail_o, err_code_o}, 5'b10000);
        chk(ncap == 2, "R6 stream stopped", ncap, 2);
        chk(!byte_ready_o, "R6 ready dropped", byte_ready_o, 0);

        finish_run();
    end

endmodule